// File: doc/BRIEF.md
# Security-Tagged Section TLB with Walk Fill

This block is a small, fully associative translation buffer for a processor that runs in two security worlds, secure and normal. A lookup carries a virtual address, the current world and a valid strobe. One cycle after the lookup is accepted, the block answers with the physical address and its physical non-secure (NS) attribute, or it finds no matching entry. Translation works on 1 MB sections, so the upper 12 bits of the virtual address form the page tag and the lower 20 bits pass through unchanged.

On a miss the block fetches one first-level descriptor. The fetch address is the translation table base followed by the 12-bit section index and two zero bits. While that fetch is outstanding, new lookups are held off through `lk_ready`. A section descriptor is installed with a world tag and an NS attribute, and both come from the world that caused the fill. A translation from one world can therefore never answer a lookup from the other. Any other descriptor type completes the lookup as a translation fault, and nothing is installed. Two flush inputs remove entries: one removes only the entries of a chosen world, the other removes every entry.

Top module: `sec_tlb`

## Requirements
- R1: A lookup accepted while `lk_valid` and `lk_ready` are both high finds a matching entry when that entry is valid, its tag equals `lk_va[31:20]` and its world tag equals `lk_secure`. On a match, the next cycle has `rsp_valid`=1 and `rsp_hit`=1, `rsp_pa` = {entry base, `lk_va[19:0]`}, and `rsp_ns` equal to the entry's stored NS attribute.
- R2: An entry filled by one world never matches a lookup from the other world. A lookup of the same address from the other world misses and starts a walk.
- R3: After an accepted lookup misses, the next cycle raises `walk_req` with `walk_addr` = {`ttb_base`, `lk_va[31:20]`, 2'b00}. `walk_req` and `walk_addr` hold until a cycle with `walk_rvalid` high. `lk_ready` stays low from the cycle after the miss until that response is taken, and the lookup result appears in the cycle after that.
- R4: `walk_ns` is 0 for a walk started from the secure world (`lk_secure`=1) and 1 for a walk started from the normal world.
- R5: The walk response is a section descriptor when `walk_rdata[1:0]`=2'b10. Its bits [31:20] hold the section base and bit 19 holds its NS bit. After a secure-world walk, such a descriptor is installed with the descriptor's NS bit. The completing response has `rsp_hit`=0, `rsp_fault`=0, `rsp_pa` = {base, VA[19:0]} and that NS bit. Later lookups hit that entry.
- R6: After a normal-world walk, the installed entry and the completing response carry NS=1, whatever bit 19 of the descriptor holds.
- R7: A walk response whose `walk_rdata[1:0]` is not 2'b10 completes with `rsp_fault`=1 and `rsp_hit`=0, and installs nothing. A repeat lookup of the same address walks again.
- R8: The block holds 8 entries, which are replaced in round-robin order. After 8 fills into an empty buffer, the ninth fill evicts the first of them, and the others still hit.
- R9: A cycle with `flush_valid`=1 invalidates only the entries whose world tag equals `flush_secure`.
- R10: A cycle with `flush_all`=1 invalidates every entry.
- R11: A flush acts only on the entries present before its clock edge. An entry filled in the same cycle as a flush stays valid. A lookup accepted in the same cycle as a flush is judged against the contents before the flush.
- R12: After reset no entry is valid, `lk_ready`=1, and both `walk_req` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ttb_base | input | 18 | Translation table base, address bits [31:14] |
| lk_valid | input | 1 | Lookup strobe |
| lk_va | input | 32 | Lookup virtual address |
| lk_secure | input | 1 | Current world: 1 = secure, 0 = normal |
| lk_ready | output | 1 | Block can accept a lookup |
| rsp_valid | output | 1 | Lookup result valid for one cycle |
| rsp_hit | output | 1 | Result came from a stored entry |
| rsp_fault | output | 1 | Walk returned a non-section descriptor |
| rsp_pa | output | 32 | Physical address |
| rsp_ns | output | 1 | Physical NS attribute |
| walk_req | output | 1 | Descriptor fetch request |
| walk_addr | output | 32 | Descriptor address |
| walk_ns | output | 1 | Security qualifier of the fetch (1 = non-secure) |
| walk_rvalid | input | 1 | Descriptor response strobe |
| walk_rdata | input | 32 | First-level descriptor |
| flush_valid | input | 1 | Flush the entries of one world |
| flush_secure | input | 1 | World selected by `flush_valid` |
| flush_all | input | 1 | Flush every entry |

## Verification
A flush can land in the same cycle as either a walk fill or a lookup accept. The bench covers both cases. It raises `flush_all` together with the descriptor response and then checks that a second lookup of that address still hits. It also raises `flush_all` together with the strobe of a lookup whose address is already stored, and expects a hit for that lookup and a walk for the next one. Together these checks show that flush works only on the contents present before the edge, while a fill or a match in the same edge is kept.

// File: rtl/sec_tlb_pkg.sv
package sec_tlb_pkg;
  localparam int VA_W    = 32;
  localparam int OFS_W   = 20;
  localparam int TAG_W   = VA_W - OFS_W;
  localparam int DSC_SH  = 2;
  localparam int TTB_W   = VA_W - TAG_W - DSC_SH;
  localparam int NS_BIT  = 19;
  localparam logic [1:0] DSC_SECTION = 2'b10;

  typedef struct packed {
    logic             sec;
    logic             ns;
    logic [TAG_W-1:0] tag;
    logic [TAG_W-1:0] pbase;
  } tlb_entry_t;

  typedef enum logic {ST_IDLE, ST_WALK} tlb_state_t;
endpackage

// File: rtl/sec_tlb_victim.sv
module sec_tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign idx = ptr_q;

  assert_rr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr_q != $past(ptr_q)));
endmodule

// File: rtl/sec_tlb_array.sv
module sec_tlb_array
  import sec_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             look_sec,
  output logic             hit,
  output logic             hit_ns,
  output logic [TAG_W-1:0] hit_pbase,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  tlb_entry_t       fill_ent,
  input  logic             flush_en,
  input  logic             flush_sec,
  input  logic             flush_all
);
  logic [ENTRIES-1:0] vld_q, vld_d, hit_vec;
  tlb_entry_t         ent_q [ENTRIES];

  // flush sees only pre-edge contents; a same-cycle fill survives
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      vld_d[i] = vld_q[i];
      if (flush_all) vld_d[i] = 1'b0;
      else if (flush_en && ent_q[i].sec == flush_sec) vld_d[i] = 1'b0;
      if (fill_en && fill_idx == IDX_W'(i)) vld_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) ent_q[fill_idx] <= fill_ent;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (ent_q[g].tag == look_tag) && (ent_q[g].sec == look_sec);
  end

  always_comb begin
    hit_ns    = 1'b0;
    hit_pbase = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_ns    = hit_ns | ent_q[i].ns;
        hit_pbase = hit_pbase | ent_q[i].pbase;
      end
    end
  end

  assign hit = |hit_vec;

  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  assert_normal_ns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !look_sec) |-> hit_ns);
  assert_flush_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_en) |=> (vld_q == '0));
endmodule

// File: rtl/sec_tlb_ctrl.sv
module sec_tlb_ctrl
  import sec_tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TTB_W-1:0] ttb_base,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             lk_secure,
  output logic             lk_ready,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [VA_W-1:0]  rsp_pa,
  output logic             rsp_ns,
  output logic             walk_req,
  output logic [VA_W-1:0]  walk_addr,
  output logic             walk_ns,
  input  logic             walk_rvalid,
  input  logic [VA_W-1:0]  walk_rdata,
  input  logic             hit,
  input  logic             hit_ns,
  input  logic [TAG_W-1:0] hit_pbase,
  output logic             fill_en,
  output tlb_entry_t       fill_ent
);
  tlb_state_t      state_q, state_d;
  logic [VA_W-1:0] pend_va_q;
  logic            pend_sec_q;
  logic            accept, pend_en;
  logic            rv_d, rh_d, rf_d, rn_d;
  logic [VA_W-1:0] rpa_d;
  logic            is_section, fill_ns;
  logic            unused_dsc;

  assign accept     = (state_q == ST_IDLE) && lk_valid;
  assign is_section = (walk_rdata[1:0] == DSC_SECTION);
  assign fill_ns    = pend_sec_q ? walk_rdata[NS_BIT] : 1'b1;
  assign unused_dsc = ^walk_rdata[NS_BIT-1:DSC_SH];

  always_comb begin
    state_d = state_q;
    pend_en = 1'b0;
    fill_en = 1'b0;
    rv_d = 1'b0; rh_d = 1'b0; rf_d = 1'b0; rn_d = 1'b0;
    rpa_d = '0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        pend_en = 1'b1;
        if (hit) begin
          rv_d  = 1'b1;
          rh_d  = 1'b1;
          rn_d  = hit_ns;
          rpa_d = {hit_pbase, lk_va[OFS_W-1:0]};
        end else begin
          state_d = ST_WALK;
        end
      end
      ST_WALK: if (walk_rvalid) begin
        state_d = ST_IDLE;
        rv_d    = 1'b1;
        if (is_section) begin
          fill_en = 1'b1;
          rn_d    = fill_ns;
          rpa_d   = {walk_rdata[VA_W-1:OFS_W], pend_va_q[OFS_W-1:0]};
        end else begin
          rf_d    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_en) begin
      pend_va_q  <= lk_va;
      pend_sec_q <= lk_secure;
    end
    if (rv_d) begin
      rsp_hit   <= rh_d;
      rsp_fault <= rf_d;
      rsp_ns    <= rn_d;
      rsp_pa    <= rpa_d;
    end
  end

  assign fill_ent  = '{sec: pend_sec_q, ns: fill_ns,
                       tag: pend_va_q[VA_W-1:OFS_W], pbase: walk_rdata[VA_W-1:OFS_W]};
  assign lk_ready  = (state_q == ST_IDLE);
  assign walk_req  = (state_q == ST_WALK);
  assign walk_addr = {ttb_base, pend_va_q[VA_W-1:OFS_W], {DSC_SH{1'b0}}};
  assign walk_ns   = ~pend_sec_q;

  assert_hit_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $past(lk_valid && lk_ready));
  assert_walk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_rvalid) |=> (walk_req && $stable(walk_addr) && $stable(walk_ns)));
  assert_walk_world_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && $past(lk_valid && lk_ready)) |-> (walk_ns == !$past(lk_secure)));
  assert_fault_no_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> !$past(fill_en));
endmodule

// File: rtl/sec_tlb.sv
module sec_tlb
  import sec_tlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TTB_W-1:0]      ttb_base,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_va,
  input  logic                  lk_secure,
  output logic                  lk_ready,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic                  rsp_fault,
  output logic [VA_W-1:0]       rsp_pa,
  output logic                  rsp_ns,
  output logic                  walk_req,
  output logic [VA_W-1:0]       walk_addr,
  output logic                  walk_ns,
  input  logic                  walk_rvalid,
  input  logic [VA_W-1:0]       walk_rdata,
  input  logic                  flush_valid,
  input  logic                  flush_secure,
  input  logic                  flush_all
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic             hit, hit_ns, fill_en;
  logic [TAG_W-1:0] hit_pbase;
  logic [IDX_W-1:0] fill_idx;
  tlb_entry_t       fill_ent;

  sec_tlb_ctrl i_ctrl (
    .clk, .rst_n, .ttb_base, .lk_valid, .lk_va, .lk_secure, .lk_ready,
    .rsp_valid, .rsp_hit, .rsp_fault, .rsp_pa, .rsp_ns,
    .walk_req, .walk_addr, .walk_ns, .walk_rvalid, .walk_rdata,
    .hit, .hit_ns, .hit_pbase, .fill_en, .fill_ent
  );

  sec_tlb_array #(.ENTRIES(ENTRIES)) i_array (
    .clk, .rst_n,
    .look_tag (lk_va[VA_W-1:OFS_W]),
    .look_sec (lk_secure),
    .hit, .hit_ns, .hit_pbase,
    .fill_en, .fill_idx, .fill_ent,
    .flush_en (flush_valid),
    .flush_sec(flush_secure),
    .flush_all
  );

  sec_tlb_victim #(.ENTRIES(ENTRIES)) i_victim (
    .clk, .rst_n, .adv(fill_en), .idx(fill_idx)
  );
endmodule

// File: tb/test_sec_tlb.sv
`timescale 1ns/1ps
module test_sec_tlb;
  localparam int VW = 100;
  localparam int WD = 50000;
  localparam logic [17:0] TTB = 18'h2A5C3;

  // {va, secure, descriptor, exp_hit, exp_fault, exp_ns, exp_pa}
  localparam logic [VW-1:0] VEC [8] = '{
    {32'h0012_3456, 1'b1, 32'hABC8_0002, 1'b0, 1'b0, 1'b1, 32'hABC2_3456},
    {32'h0012_3456, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 32'hABC2_3456},
    {32'h0012_3456, 1'b0, 32'h5550_0002, 1'b0, 1'b0, 1'b1, 32'h5552_3456},
    {32'h0012_3456, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 32'h5552_3456},
    {32'h0012_3456, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 32'hABC2_3456},
    {32'h0340_0010, 1'b1, 32'h1230_0002, 1'b0, 1'b0, 1'b0, 32'h1230_0010},
    {32'h0340_0010, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'h1230_0010},
    {32'h0780_0000, 1'b0, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 32'h0000_0000}
  };
  localparam string VREQ [8] = '{"R5", "R1", "R6", "R1", "R2", "R5", "R1", "R7"};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_secure = 1'b0;
  logic [31:0] lk_va = '0;
  logic        walk_rvalid = 1'b0;
  logic [31:0] walk_rdata = '0;
  logic        flush_valid = 1'b0, flush_secure = 1'b0, flush_all = 1'b0;
  logic        lk_ready, rsp_valid, rsp_hit, rsp_fault, rsp_ns, walk_req, walk_ns;
  logic [31:0] rsp_pa, walk_addr;

  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  sec_tlb i_sec_tlb (
    .clk, .rst_n, .ttb_base(TTB), .lk_valid, .lk_va, .lk_secure, .lk_ready,
    .rsp_valid, .rsp_hit, .rsp_fault, .rsp_pa, .rsp_ns,
    .walk_req, .walk_addr, .walk_ns, .walk_rvalid, .walk_rdata,
    .flush_valid, .flush_secure, .flush_all
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // one lookup; answers a walk with desc; fa/ff raise flush_all at accept / at fill
  task automatic lookup(input logic [31:0] va, input bit sec, input logic [31:0] desc,
                        input bit fa, input bit ff,
                        output bit walked, output bit h, output bit f,
                        output bit ns, output logic [31:0] pa);
    logic [31:0] exp_wa;
    exp_wa = {TTB, va[31:20], 2'b00};
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_secure = sec; flush_all = fa;
    @(negedge clk);
    lk_valid = 1'b0; flush_all = 1'b0;
    walked = !rsp_valid;
    if (walked) begin
      chk(walk_req == 1'b1, "R3", "walk_req after miss", 32'(walk_req), 32'd1);
      chk(walk_addr == exp_wa, "R3", "walk_addr", walk_addr, exp_wa);
      chk(walk_ns == !sec, "R4", "walk_ns", 32'(walk_ns), 32'(!sec));
      chk(lk_ready == 1'b0, "R3", "lk_ready during walk", 32'(lk_ready), 32'd0);
      repeat (2) @(negedge clk);
      chk(walk_req && walk_addr == exp_wa, "R3", "walk held", walk_addr, exp_wa);
      walk_rvalid = 1'b1; walk_rdata = desc; flush_all = ff;
      @(negedge clk);
      walk_rvalid = 1'b0; flush_all = 1'b0;
      chk(rsp_valid == 1'b1, "R3", "rsp_valid after fill", 32'(rsp_valid), 32'd1);
      chk(lk_ready == 1'b1, "R3", "lk_ready after fill", 32'(lk_ready), 32'd1);
    end
    h = rsp_hit; f = rsp_fault; ns = rsp_ns; pa = rsp_pa;
  endtask

  task automatic pulse_flush(input bit all, input bit one, input bit sec);
    @(negedge clk);
    flush_all = all; flush_valid = one; flush_secure = sec;
    @(negedge clk);
    flush_all = 1'b0; flush_valid = 1'b0;
  endtask

  initial begin
    bit w, h, f, ns;
    logic [31:0] pa;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(lk_ready == 1'b1, "R12", "lk_ready in reset", 32'(lk_ready), 32'd1);
    chk(walk_req == 1'b0, "R12", "walk_req in reset", 32'(walk_req), 32'd0);
    chk(rsp_valid == 1'b0, "R12", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    lookup(32'h0012_3456, 1'b1, 32'h0000_0001, 1'b0, 1'b0, w, h, f, ns, pa);
    chk(w == 1'b1, "R12", "empty after reset walks", 32'(w), 32'd1);

    for (int i = 0; i < 8; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      lookup(v[99:68], v[67], v[66:35], 1'b0, 1'b0, w, h, f, ns, pa);
      chk(h == v[34], VREQ[i], $sformatf("vec%0d hit", i), 32'(h), 32'(v[34]));
      chk(w == !v[34], VREQ[i], $sformatf("vec%0d walk", i), 32'(w), 32'(!v[34]));
      chk(f == v[33], VREQ[i], $sformatf("vec%0d fault", i), 32'(f), 32'(v[33]));
      if (!v[33]) begin
        chk(ns == v[32], VREQ[i], $sformatf("vec%0d ns", i), 32'(ns), 32'(v[32]));
        chk(pa == v[31:0], VREQ[i], $sformatf("vec%0d pa", i), pa, v[31:0]);
      end
    end
    // R7 fault installed nothing
    lookup(32'h0780_0000, 1'b0, 32'h0000_0000, 1'b0, 1'b0, w, h, f, ns, pa);
    chk(w == 1'b1, "R7", "refetch after fault", 32'(w), 32'd1);

    // R9 world flush: drop normal entries only
    pulse_flush(1'b0, 1'b1, 1'b0);
    lookup(32'h0012_3456, 1'b1, 32'h0000_0000, 1'b0, 1'b0, w, h, f, ns, pa);
    chk(h == 1'b1, "R9", "secure kept", 32'(h), 32'd1);
    lookup(32'h0012_3456, 1'b0, 32'h5550_0002, 1'b0, 1'b0, w, h, f, ns, pa);
    chk(w == 1'b1, "R9", "normal flushed", 32'(w), 32'd1);

    // R10 flush all
    pulse_flush(1'b1, 1'b0, 1'b0);
    lookup(32'h0012_3456, 1'b1, 32'hABC8_0002, 1'b0, 1'b0, w, h, f, ns, pa);
    chk(w == 1'b1, "R10", "secure flushed", 32'(w), 32'd1);

    // R11 flush at the fill edge keeps the new entry
    lookup(32'h0990_0000, 1'b1, 32'h7770_0002, 1'b0, 1'b1, w, h, f, ns, pa);
    lookup(32'h0990_0000, 1'b1, 32'h0000_0000, 1'b0, 1'b0, w, h, f, ns, pa);
    chk(h == 1'b1, "R11", "fill survives flush", 32'(h), 32'd1);
    chk(pa == 32'h7770_0000, "R11", "fill pa", pa, 32'h7770_0000);
    // R11 lookup at the flush edge uses old contents
    lookup(32'h0990_0000, 1'b1, 32'h0000_0000, 1'b1, 1'b0, w, h, f, ns, pa);
    chk(h == 1'b1, "R11", "lookup with flush hits", 32'(h), 32'd1);
    lookup(32'h0990_0000, 1'b1, 32'h7770_0002, 1'b0, 1'b0, w, h, f, ns, pa);
    chk(w == 1'b1, "R11", "flush took effect", 32'(w), 32'd1);

    // R8 round robin over 8 entries
    pulse_flush(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 9; k++) begin
      logic [31:0] va;
      va = 32'h1000_0000 + (32'(k) << 20);
      lookup(va, 1'b1, {12'h200 + 12'(k), 20'h0_0002}, 1'b0, 1'b0, w, h, f, ns, pa);
      chk(w == 1'b1, "R8", $sformatf("fill %0d walks", k), 32'(w), 32'd1);
    end
    lookup(32'h1010_0000, 1'b1, 32'h0000_0000, 1'b0, 1'b0, w, h, f, ns, pa);
    chk(h == 1'b1, "R8", "second fill kept", 32'(h), 32'd1);
    chk(pa == 32'h2010_0000, "R8", "second fill pa", pa, 32'h2010_0000);
    lookup(32'h1000_0000, 1'b1, 32'h2000_0002, 1'b0, 1'b0, w, h, f, ns, pa);
    chk(w == 1'b1, "R8", "first fill evicted", 32'(w), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule